// File: doc/BRIEF.md
# Serial Register Command Decoder

This block is a serial-peripheral slave. It turns command sequences that a host clocks in over a four-wire serial link into reads and writes on a byte-wide internal register bus. The host pulls chip select low, clocks in a header byte, and then sends a run of bytes whose meaning depends on the header. Read data comes back to the host on a separate output line during the byte that follows the request.

Two sequence formats exist. In the paired format, address bytes and data bytes alternate for as long as chip select stays low. In the run format, a single address byte is followed by any number of data bytes. A run aimed at the low FIFO window hits the same address every time. A run anywhere else walks upward through the map. All serial inputs are brought into the system clock domain through a short synchroniser, and every bus strobe lasts exactly one system clock.

Top module: `sreg_cmd_decoder`

## Requirements
- R1: Serial input is sampled on the rising edge of `spi_sck`, MSB first. `spi_miso` changes only after a falling edge of `spi_sck`, or when chip select goes high. A `spi_sck` half period must last at least 8 `clk` cycles.
- R2: Header 0x41 selects the paired format. Each address byte carries the address in bits 6..0 and the direction in bit 7 (1 = read, 0 = write). Exactly one data byte follows each address byte, and there may be any number of such pairs.
- R3: A write raises `reg_wr` for one cycle, once per complete data byte, with `reg_addr` and `reg_wdata` valid in that cycle.
- R4: A read raises `reg_rd` for one cycle when its address byte completes. `reg_rdata` is taken one clock after `reg_rd`. It is shifted out MSB first during the next byte.
- R5: Header 0x43 selects the run format. One address byte is followed by data bytes that are all reads or all writes, as bit 7 of that address byte selects.
- R6: In a run, an address of 0x1F or below stays fixed for every data byte. A higher address advances by one per data byte and saturates at 0x7F. A read run issues one more read after each data byte to fetch the next byte, so n data bytes cause n+1 reads.
- R7: Addresses 0x70 to 0x7F issue no strobe. A read of such an address returns 0x00.
- R8: Any other header value makes the rest of the transaction ignored: no strobes, and `spi_miso` stays 0.
- R9: Chip select going high ends any sequence at once. A partial byte issues no write, and the next transaction starts again with a header.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle, and never for two cycles in a row.
- R11: Out of reset, `reg_wr`, `reg_rd` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data valid with `reg_wr` |
| reg_rdata | input | 8 | Read data, valid one clock after `reg_rd` |

## Verification
The bench builds the block with its default parameters: header codes 0x41 and 0x43, a map top of 0x6F, a FIFO window top of 0x1F, and two synchroniser stages. With these values, a run write started at 0x6E crosses the map edge in its third byte. A run read at 0x05 repeatedly pops a modelled FIFO, whose pop count the bench predicts on its own. The two-stage synchroniser combined with a 10-cycle serial half period is the tightest read turnaround the bench reaches: read data must be loaded before the falling edge that closes the address byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_PADDR,
    ST_PDATA,
    ST_RADDR,
    ST_RDATA,
    ST_DROP
  } seq_st_e;

  // address lies inside the decoded map
  function automatic logic in_map(input logic [6:0] a, input logic [6:0] top);
    return (a <= top);
  endfunction

  // next address of a run: FIFO window holds, others climb and saturate
  function automatic logic [6:0] run_step(input logic [6:0] a, input logic [6:0] fifo_top);
    if (a <= fifo_top || a == 7'h7F) return a;
    return a + 7'd1;
  endfunction

  function automatic seq_st_e hdr_decode(input logic [7:0] h, input logic [7:0] pairs,
                                         input logic [7:0] run);
    if (h == pairs) return ST_PADDR;
    if (h == run) return ST_RADDR;
    return ST_DROP;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sreg_shift.sv
module sreg_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       mosi_s,
  input  logic       cs_act,
  input  logic       load_rd,
  input  logic [7:0] rd_data,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic       miso
);
  logic       sck_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  wire sck_rise  = sck_s & ~sck_d;
  wire sck_fall  = ~sck_s & sck_d;
  wire byte_done = cs_act & sck_rise & (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      byte_val <= '0;
      byte_vld <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      byte_vld <= byte_done;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= {rx_sr[5:0], mosi_s};
        if (bit_cnt == 3'd7) byte_val <= {rx_sr, mosi_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (!cs_act) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (load_rd) begin
      tx_sr <= rd_data;
    end else if (byte_vld) begin
      tx_sr <= '0;
    end else if (sck_fall) begin
      miso  <= tx_sr[7];
      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  // R1: one byte event per eighth rising edge
  a_r1_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  // R1: output line moves only after a falling serial edge or deselect
  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || $past(!cs_act)));
  // R9: deselect silences the output line
  a_r9_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);
endmodule

// File: rtl/sreg_seq.sv
module sreg_seq
  import sreg_pkg::*;
#(
  parameter logic [7:0] HDR_PAIRS = 8'h41,
  parameter logic [7:0] HDR_RUN   = 8'h43,
  parameter logic [6:0] MAP_TOP   = 7'h6F,
  parameter logic [6:0] FIFO_TOP  = 7'h1F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       byte_vld,
  input  logic [7:0] byte_val,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       load_rd
);
  seq_st_e    st;
  logic [6:0] ptr;
  logic       dir_rd;

  wire [6:0] b_addr = byte_val[6:0];
  wire [6:0] ptr_nx = run_step(ptr, FIFO_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      ptr       <= '0;
      dir_rd    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      load_rd   <= 1'b0;
    end else begin
      reg_rd  <= 1'b0;
      reg_wr  <= 1'b0;
      load_rd <= reg_rd;
      if (!cs_act) begin
        st <= ST_HDR;
      end else if (byte_vld) begin
        unique case (st)
          ST_HDR: st <= hdr_decode(byte_val, HDR_PAIRS, HDR_RUN);
          ST_PADDR, ST_RADDR: begin
            ptr      <= b_addr;
            reg_addr <= b_addr;
            dir_rd   <= byte_val[7];
            reg_rd   <= byte_val[7] & in_map(b_addr, MAP_TOP);
            st       <= (st == ST_PADDR) ? ST_PDATA : ST_RDATA;
          end
          ST_PDATA: begin
            reg_addr  <= ptr;
            reg_wdata <= byte_val;
            reg_wr    <= !dir_rd & in_map(ptr, MAP_TOP);
            st        <= ST_PADDR;
          end
          ST_RDATA: begin
            ptr <= ptr_nx;
            if (dir_rd) begin
              reg_addr <= ptr_nx;
              reg_rd   <= in_map(ptr_nx, MAP_TOP);
            end else begin
              reg_addr  <= ptr;
              reg_wdata <= byte_val;
              reg_wr    <= in_map(ptr, MAP_TOP);
            end
          end
          default: st <= ST_DROP;
        endcase
      end
    end
  end

  // R10: strobes exclusive and single-cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  // R7: no strobe outside the map
  a_r7_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_addr <= MAP_TOP));
  // R3: a write follows a completed byte
  a_r3_wr_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(byte_vld));
  // R9: deselect stops all bus traffic
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!reg_wr && !reg_rd));
endmodule

// File: rtl/sreg_cmd_decoder.sv
module sreg_cmd_decoder #(
  parameter logic [7:0] HDR_PAIRS   = 8'h41,
  parameter logic [7:0] HDR_RUN     = 8'h43,
  parameter logic [6:0] MAP_TOP     = 7'h6F,
  parameter logic [6:0] FIFO_TOP    = 7'h1F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q;
  logic       byte_vld;
  logic [7:0] byte_val;
  logic       load_rd;

  // bit 2: serial clock, bit 1: chip select (idles high), bit 0: data in
  sreg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q(sync_q)
  );

  wire cs_act = ~sync_q[1];

  sreg_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sync_q[2]), .mosi_s(sync_q[0]), .cs_act(cs_act),
    .load_rd(load_rd), .rd_data(reg_rdata),
    .byte_vld(byte_vld), .byte_val(byte_val), .miso(spi_miso)
  );

  sreg_seq #(.HDR_PAIRS(HDR_PAIRS), .HDR_RUN(HDR_RUN),
             .MAP_TOP(MAP_TOP), .FIFO_TOP(FIFO_TOP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .byte_vld(byte_vld), .byte_val(byte_val),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .load_rd(load_rd)
  );

  // R4: read data loaded after the read strobe, never together with a new byte
  a_r4_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !load_rd);
endmodule

// File: tb/sim_sreg_cmd_decoder.sv
`timescale 1ns/1ps
module sim_sreg_cmd_decoder;
  localparam int HALF = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, reg_rd, reg_wr;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  sreg_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0, fails = 0, pops = 0, exp_pops = 0;
  logic [7:0] mem [128];
  logic [15:0] exp_q[$];
  string exp_tag[$];
  bit prev_wr = 0, prev_rd = 0, done = 0;

  // register file model; addresses 0x00..0x1F act as a FIFO that pops on read
  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    reg_rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (reg_rd) begin
      if (reg_addr <= 7'h1F) begin reg_rdata <= 8'hA0 + 8'(pops); pops++; end
      else reg_rdata <= mem[reg_addr];
    end
    if (reg_wr) mem[reg_addr] <= reg_wdata;
  end

  // monitor: compare bus events against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr || reg_rd) begin
        checks++;
        if ((reg_wr && reg_rd) || (reg_wr && prev_wr) || (reg_rd && prev_rd)) begin
          fails++;
          $display("FAIL R10: wr=%0b rd=%0b prev_wr=%0b prev_rd=%0b, expected single exclusive strobe",
                   reg_wr, reg_rd, prev_wr, prev_rd);
        end
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8/R7: unexpected %s at 0x%02h data 0x%02h, expected none",
                   reg_wr ? "write" : "read", reg_addr, reg_wdata);
        end else begin
          logic [15:0] it;
          string tg;
          it = exp_q.pop_front();
          tg = exp_tag.pop_front();
          if (it[15] != reg_wr || it[14:8] != reg_addr || (reg_wr && it[7:0] != reg_wdata)) begin
            fails++;
            $display("FAIL %s: got wr=%0b addr=0x%02h data=0x%02h, expected wr=%0b addr=0x%02h data=0x%02h",
                     tg, reg_wr, reg_addr, reg_wdata, it[15], it[14:8], it[7:0]);
          end
        end
      end
      prev_wr = reg_wr;
      prev_rd = reg_rd;
    end
  end

  task automatic exp_push(input bit is_wr, input logic [6:0] a, input logic [7:0] d, input string tg);
    exp_q.push_back({is_wr, a, d});
    exp_tag.push_back(tg);
  endtask

  task automatic check_val(input string tg, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h, expected 0x%02h", tg, got, exp);
    end
  endtask

  task automatic drain(input string tg);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d bus events missing, expected 0", tg, exp_q.size());
      exp_q.delete();
      exp_tag.delete();
    end
  endtask

  task automatic spi_begin;
    spi_cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic spi_end;
    #(HALF);
    spi_cs_n = 1'b1;
    #(8*HALF);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      #(HALF);
      spi_sck = 1'b1;
      rx[i] = spi_miso;
      #(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      #(HALF);
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic pair_read(input logic [6:0] a, input logic [7:0] exp, input string tg);
    logic [7:0] rx;
    exp_push(1'b0, a, 8'h00, tg);
    spi_begin();
    spi_byte(8'h41, rx);
    spi_byte({1'b1, a}, rx);
    spi_byte(8'h00, rx);
    check_val(tg, rx, exp);
    spi_end();
    drain(tg);
  endtask

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    // R11: reset state
    check_val("R11 miso", {7'd0, spi_miso}, 8'h00);
    check_val("R11 strobes", {6'd0, reg_wr, reg_rd}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: paired writes
    exp_push(1'b1, 7'h30, 8'h5A, "R2");
    exp_push(1'b1, 7'h63, 8'hC3, "R3");
    exp_push(1'b1, 7'h25, 8'h11, "R2");
    spi_begin();
    spi_byte(8'h41, rx);
    spi_byte(8'h30, rx); spi_byte(8'h5A, rx);
    spi_byte(8'h63, rx); spi_byte(8'hC3, rx);
    spi_byte(8'h25, rx); spi_byte(8'h11, rx);
    spi_end();
    drain("R2");

    // R4 R1: paired reads, MSB first
    pair_read(7'h30, 8'h5A, "R4");
    pair_read(7'h63, 8'hC3, "R1");

    // R5 R6: run write climbing from 0x28
    exp_push(1'b1, 7'h28, 8'h01, "R5");
    exp_push(1'b1, 7'h29, 8'h02, "R6");
    exp_push(1'b1, 7'h2A, 8'h03, "R6");
    spi_begin();
    spi_byte(8'h43, rx);
    spi_byte(8'h28, rx);
    spi_byte(8'h01, rx); spi_byte(8'h02, rx); spi_byte(8'h03, rx);
    spi_end();
    drain("R5");

    // R5 R6: run read of three bytes, four reads
    for (int k = 0; k < 4; k++) exp_push(1'b0, 7'h28 + 7'(k), 8'h00, "R6");
    spi_begin();
    spi_byte(8'h43, rx);
    spi_byte(8'hA8, rx);
    spi_byte(8'h00, rx); check_val("R5 run byte0", rx, 8'h01);
    spi_byte(8'h00, rx); check_val("R6 run byte1", rx, 8'h02);
    spi_byte(8'h00, rx); check_val("R6 run byte2", rx, 8'h03);
    spi_end();
    drain("R6");

    // R6: FIFO window read holds the address
    for (int k = 0; k < 4; k++) exp_push(1'b0, 7'h05, 8'h00, "R6 fifo");
    spi_begin();
    spi_byte(8'h43, rx);
    spi_byte(8'h85, rx);
    for (int k = 0; k < 3; k++) begin
      spi_byte(8'h00, rx);
      check_val("R6 fifo data", rx, 8'hA0 + 8'(exp_pops + k));
    end
    exp_pops += 4;
    spi_end();
    drain("R6 fifo");

    // R6: FIFO window write holds the address
    exp_push(1'b1, 7'h03, 8'h07, "R6 fifo wr");
    exp_push(1'b1, 7'h03, 8'h08, "R6 fifo wr");
    spi_begin();
    spi_byte(8'h43, rx);
    spi_byte(8'h03, rx);
    spi_byte(8'h07, rx); spi_byte(8'h08, rx);
    spi_end();
    drain("R6 fifo wr");

    // R7: out-of-map write and read
    spi_begin();
    spi_byte(8'h41, rx);
    spi_byte(8'h70, rx); spi_byte(8'hFF, rx);
    spi_byte(8'hF5, rx); spi_byte(8'h00, rx);
    check_val("R7 read 0x75", rx, 8'h00);
    spi_end();
    drain("R7");

    // R7: run write crossing the map top
    exp_push(1'b1, 7'h6E, 8'hAA, "R7 edge");
    exp_push(1'b1, 7'h6F, 8'hBB, "R7 edge");
    spi_begin();
    spi_byte(8'h43, rx);
    spi_byte(8'h6E, rx);
    spi_byte(8'hAA, rx); spi_byte(8'hBB, rx); spi_byte(8'hCC, rx);
    spi_end();
    drain("R7 edge");
    pair_read(7'h6F, 8'hBB, "R7 readback");

    // R8: unknown header ignores the rest
    spi_begin();
    spi_byte(8'h99, rx);
    spi_byte(8'h30, rx); spi_byte(8'h77, rx);
    spi_byte(8'hB0, rx); spi_byte(8'h00, rx);
    check_val("R8 miso", rx, 8'h00);
    spi_end();
    drain("R8");
    pair_read(7'h30, 8'h5A, "R8 readback");

    // R9: partial byte then deselect
    spi_begin();
    spi_byte(8'h41, rx);
    spi_byte(8'h31, rx);
    spi_bits(8'hFF, 4);
    spi_end();
    drain("R9");
    pair_read(7'h31, 8'h00, "R9 restart");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule